// File: doc/BRIEF.md
# Addressed Packet Receiver with Filtering

This block sits behind a byte-level serial receiver and turns a stream of bytes into a stored packet. A frame starts with a destination byte and a length byte. The length byte counts the payload only. After it come the payload bytes and one trailing check byte. The block accepts the frame only when the destination matches the node's own address or is the broadcast value 0xFF. Before it stores anything past the destination byte, it checks that the whole frame fits the buffer capacity given at its input. Accepted bytes go out on a simple write port into a local buffer, starting at address 0 for every frame.

Each frame ends with exactly one outcome: success, not-for-this-node, size error or I/O error. The block raises a one-clock done pulse and holds a status code. It also keeps saturating statistics counters, one each for good frames, size errors and I/O errors, and a select input reads them out. After a not-for-me or error outcome the block discards bytes until an idle or frame-reset strobe arrives. Checking the trailing byte and the bit-level serial timing are left to other logic.

Top module: `pkt_rx_filter`

## Requirements
- R1: If `buf_cap_i` is below 3, the first byte event of a frame (valid byte or error strobe) ends the frame with status 2 (size error), performs no buffer write and increments the size-error counter.
- R2: A first byte equal to `node_addr_i` or to 0xFF is accepted and written to buffer address 0.
- R3: A first byte matching neither ends the frame with status 0 (not for this node), performs no write and changes no counter.
- R4: The length byte plus one is written to address 1, the following length+1 bytes are written in order from address 2, and the done pulse of the last write carries status 1 (success) and increments the good-frame counter.
- R5: If length+1 exceeds `buf_cap_i` minus 2, the length byte ends the frame with status 2, is not written, and the size-error counter increments.
- R6: A `byte_err_i` strobe in any byte position of an accepted frame, or in place of the first byte, ends the frame with status 3 (I/O error) and increments the I/O counter. The error strobe wins over `byte_vld_i` in the same cycle.
- R7: `idle_i` while the length or payload bytes are awaited ends the frame with status 3, increments the I/O counter, and leaves the block ready for a new destination byte without a further idle.
- R8: After a status 0, 2 or 3 outcome from a byte, all bytes are ignored, with no writes and no done pulse, until `idle_i` is seen.
- R9: Every frame gives exactly one done pulse, one clock wide, and its writes begin at address 0.
- R10: Counters are `CNT_W` bits (default 16) and saturate at all ones instead of wrapping.
- R11: `cnt_sel_i` picks the counter on `cnt_o`: 0 good frames, 1 size errors, 2 I/O errors, 3 reads zero.
- R12: After reset, `done_o`, `wr_en_o`, `status_o` and every counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| node_addr_i | input | 8 | This node's address |
| buf_cap_i | input | CAP_W | Buffer capacity in bytes |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| byte_err_i | input | 1 | Byte-level receive failure strobe |
| idle_i | input | 1 | Line idle / frame reset strobe |
| wr_en_o | output | 1 | Buffer write enable |
| wr_addr_o | output | CAP_W | Buffer write address |
| wr_data_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-clock frame outcome pulse |
| status_o | output | 2 | Outcome of the last frame: 0 not for me, 1 ok, 2 size, 3 I/O |
| cnt_sel_i | input | 2 | Statistics counter select |
| cnt_o | output | CNT_W | Selected statistics counter |

## Verification
The bench goes after the exact-fit boundary, where length+1 equals capacity minus 2. A design with an off-by-one size check would fail that frame or accept the one after it. Capacities of 0 to 2 must give a size error before any write, or the buffer would be overrun. Error strobes land on the first, second and last byte. A design that kept the length byte or ran on after an error would show extra writes, a second done pulse, or a counter bumped in the wrong class. A narrow-counter instance is driven past its all-ones value, which a wrapping counter would fail. An idle in the middle of a frame must return the block to the destination state, or the next frame would be lost.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [1:0] {
    ST_NFM  = 2'd0,
    ST_OK   = 2'd1,
    ST_SIZE = 2'd2,
    ST_IO   = 2'd3
  } rx_status_e;

  typedef enum logic [1:0] {
    S_DEST,
    S_LEN,
    S_PAY,
    S_DROP
  } rx_state_e;

  localparam int NUM_CNT = 3;
  localparam logic [7:0] BCAST_ADDR = 8'hFF;

  // counter index -> outcome it counts
  function automatic rx_status_e cnt_code(input int idx);
    case (idx)
      0:       return ST_OK;
      1:       return ST_SIZE;
      default: return ST_IO;
    endcase
  endfunction

endpackage

// File: rtl/pkt_rx_addr_match.sv
module pkt_rx_addr_match
  import pkt_rx_pkg::*;
(
  input  logic [7:0] dest_i,
  input  logic [7:0] node_i,
  output logic       hit_o
);
  logic uni, bc;
  assign uni   = (dest_i == node_i);
  assign bc    = (dest_i == BCAST_ADDR);
  assign hit_o = uni | bc;
endmodule

// File: rtl/pkt_rx_size_chk.sv
module pkt_rx_size_chk #(
  parameter int CAP_W = 8
) (
  input  logic [CAP_W-1:0] cap_i,
  input  logic [7:0]       len_i,
  output logic             cap_ok_o,
  output logic             fit_o,
  output logic [8:0]       adj_o
);
  localparam int SW = ((CAP_W > 9) ? CAP_W : 9) + 2;

  logic [SW-1:0] have, need;

  assign have     = SW'(cap_i);
  assign adj_o    = 9'(len_i) + 9'd1;
  // header (2) + payload + check byte
  assign need     = SW'(adj_o) + SW'(2);
  assign cap_ok_o = (have >= SW'(3));
  assign fit_o    = (need <= have);
endmodule

// File: rtl/pkt_rx_sat_ctr.sv
module pkt_rx_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q_o <= '0;
    else if (inc_i && q_o != MAX) q_o <= q_o + 1'b1;
  end

  AST_CNT_HOLD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o == MAX) |=> (q_o == MAX)); // R10
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && q_o != MAX) |=> (q_o == $past(q_o) + 1'b1)); // R10
  AST_CNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int CAP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       node_addr_i,
  input  logic [CAP_W-1:0] buf_cap_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_err_i,
  input  logic             idle_i,
  output logic             wr_en_o,
  output logic [CAP_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             done_o,
  output logic [1:0]       status_o,
  input  logic [1:0]       cnt_sel_i,
  output logic [CNT_W-1:0] cnt_o
);

  rx_state_e        state_q, state_d;
  logic [CAP_W-1:0] ptr_q, ptr_d;
  logic [8:0]       rem_q, rem_d;

  logic             hit, cap_ok, fit;
  logic [8:0]       adj;

  logic             wr_d;
  logic [CAP_W-1:0] waddr_d;
  logic [7:0]       wdata_d;
  logic             fin;
  rx_status_e       code;

  logic             ev_byte;
  assign ev_byte = byte_vld_i & ~byte_err_i;

  pkt_rx_addr_match u_match (
    .dest_i (byte_i),
    .node_i (node_addr_i),
    .hit_o  (hit)
  );

  pkt_rx_size_chk #(.CAP_W(CAP_W)) u_size (
    .cap_i    (buf_cap_i),
    .len_i    (byte_i),
    .cap_ok_o (cap_ok),
    .fit_o    (fit),
    .adj_o    (adj)
  );

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    wr_d    = 1'b0;
    waddr_d = ptr_q;
    wdata_d = byte_i;
    fin     = 1'b0;
    code    = ST_NFM;
    unique case (state_q)
      S_DEST: begin
        if (byte_vld_i || byte_err_i) begin
          if (!cap_ok) begin
            fin = 1'b1; code = ST_SIZE; state_d = S_DROP;
          end else if (byte_err_i) begin
            fin = 1'b1; code = ST_IO; state_d = S_DROP;
          end else if (hit) begin
            wr_d    = 1'b1;
            waddr_d = '0;
            ptr_d   = CAP_W'(1);
            state_d = S_LEN;
          end else begin
            fin = 1'b1; code = ST_NFM; state_d = S_DROP;
          end
        end
      end
      S_LEN: begin
        if (idle_i) begin
          fin = 1'b1; code = ST_IO; state_d = S_DEST;
        end else if (byte_err_i) begin
          fin = 1'b1; code = ST_IO; state_d = S_DROP;
        end else if (ev_byte) begin
          if (!fit) begin
            fin = 1'b1; code = ST_SIZE; state_d = S_DROP;
          end else begin
            wr_d    = 1'b1;
            wdata_d = adj[7:0];
            ptr_d   = ptr_q + 1'b1;
            rem_d   = adj;
            state_d = S_PAY;
          end
        end
      end
      S_PAY: begin
        if (idle_i) begin
          fin = 1'b1; code = ST_IO; state_d = S_DEST;
        end else if (byte_err_i) begin
          fin = 1'b1; code = ST_IO; state_d = S_DROP;
        end else if (ev_byte) begin
          wr_d  = 1'b1;
          ptr_d = ptr_q + 1'b1;
          rem_d = rem_q - 9'd1;
          if (rem_q == 9'd1) begin
            fin = 1'b1; code = ST_OK; state_d = S_DEST;
          end
        end
      end
      S_DROP: begin
        if (idle_i) state_d = S_DEST;
      end
      default: state_d = S_DEST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_DEST;
      ptr_q     <= '0;
      rem_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      status_o  <= 2'(ST_NFM);
    end else begin
      state_q   <= state_d;
      ptr_q     <= ptr_d;
      rem_q     <= rem_d;
      wr_en_o   <= wr_d;
      wr_addr_o <= waddr_d;
      wr_data_o <= wdata_d;
      done_o    <= fin;
      if (fin) status_o <= 2'(code);
    end
  end

  logic [CNT_W-1:0] cnt_q [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic inc;
    assign inc = fin && (code == cnt_code(g));
    pkt_rx_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc),
      .q_o    (cnt_q[g])
    );
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (cnt_sel_i == 2'(i)) cnt_o = cnt_q[i];
  end

  AST_WR_IN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o < $past(buf_cap_i))); // R5
  AST_HDR_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_addr_o == '0) |->
      (wr_data_o == BCAST_ADDR || wr_data_o == $past(node_addr_i))); // R2
  AST_NO_WR_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && done_o && status_o != 2'(ST_OK))); // R8
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DROP) |=> !wr_en_o && !done_o); // R8

endmodule

// File: tb/sim_pkt_rx_filter.sv
`timescale 1ns/1ps
module sim_pkt_rx_filter;
  localparam int CAP_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]       node = 8'h5A;
  logic [CAP_W-1:0] cap  = 8'd40;
  logic             vld = 1'b0, err = 1'b0, idle = 1'b0;
  logic [7:0]       dat = 8'h00;
  logic [1:0]       sel = 2'd0;
  logic             wr_en, done;
  logic [CAP_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic [1:0]       status;
  logic [15:0]      cnt;

  pkt_rx_filter #(.CAP_W(CAP_W), .CNT_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .node_addr_i(node), .buf_cap_i(cap),
    .byte_vld_i(vld), .byte_i(dat), .byte_err_i(err), .idle_i(idle),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .done_o(done), .status_o(status), .cnt_sel_i(sel), .cnt_o(cnt)
  );

  // narrow counters for the saturation check
  logic             v1 = 1'b0, i1 = 1'b0;
  logic [1:0]       sel1 = 2'd1;
  logic             wr1, dn1;
  logic [CAP_W-1:0] wa1;
  logic [7:0]       wd1;
  logic [1:0]       st1;
  logic [2:0]       cnt1;

  pkt_rx_filter #(.CAP_W(CAP_W), .CNT_W(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .node_addr_i(8'h01), .buf_cap_i(8'd2),
    .byte_vld_i(v1), .byte_i(8'h01), .byte_err_i(1'b0), .idle_i(i1),
    .wr_en_o(wr1), .wr_addr_o(wa1), .wr_data_o(wd1),
    .done_o(dn1), .status_o(st1), .cnt_sel_i(sel1), .cnt_o(cnt1)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, done_cnt = 0;
  logic [7:0] mem [0:511];
  logic [7:0] pay [0:256];
  int exp_ok = 0, exp_sz = 0, exp_io = 0;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] = wr_data;
      wr_cnt++;
    end
    if (done) done_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // expected outcome: status code and number of buffer writes
  function automatic int exp_status(int c, int nd, int d, int l, int k);
    if (c < 3) return 2;
    if (k == 0) return 3;
    if (d != nd && d != 255) return 0;
    if (k == 1) return 3;
    if (l + 1 > c - 2) return 2;
    if (k >= 2) return 3;
    return 1;
  endfunction

  function automatic int exp_writes(int c, int nd, int d, int l, int k);
    if (c < 3 || k == 0) return 0;
    if (d != nd && d != 255) return 0;
    if (k == 1) return 1;
    if (l + 1 > c - 2) return 1;
    if (k >= 2) return k;
    return l + 3;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_cnts(input string tag);
    int v [3];
    v[0] = exp_ok; v[1] = exp_sz; v[2] = exp_io;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1;
      if (s < 3) check(cnt == 16'(v[s]), {tag, " R11 counter"}, int'(cnt), v[s]);
      else       check(cnt == 16'd0, "R11 sel 3 zero", int'(cnt), 0);
    end
  endtask

  // k = index of byte replaced by an error strobe, -1 for none
  task automatic run_frame(input int d, input int l, input int k, input string tag);
    int n, es, ew, bad;
    n = l + 3;
    for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
    wr_cnt = 0; done_cnt = 0;
    for (int i = 0; i < n; i++) begin
      vld = (i != k); err = (i == k);
      dat = (i == 0) ? 8'(d) : (i == 1) ? 8'(l) : pay[i-2];
      tick();
    end
    vld = 1'b0; err = 1'b0;
    idle = 1'b1; tick(); idle = 1'b0;
    tick(); tick();
    es = exp_status(int'(cap), int'(node), d, l, k);
    ew = exp_writes(int'(cap), int'(node), d, l, k);
    check(int'(status) == es, {tag, " R1/R3/R5/R6 status"}, int'(status), es);
    check(done_cnt == 1, {tag, " R9 one done"}, done_cnt, 1);
    check(wr_cnt == ew, {tag, " R8 write count"}, wr_cnt, ew);
    if (es == 1) begin
      bad = 0;
      if (mem[0] != 8'(d)) bad++;
      if (mem[1] != 8'(l + 1)) bad++;
      for (int i = 0; i <= l; i++) if (mem[i+2] != pay[i]) bad++;
      check(bad == 0, {tag, " R4 buffer content"}, bad, 0);
      exp_ok++;
    end else if (es == 2) exp_sz++;
    else if (es == 3) exp_io++;
    if (ew > 0) check(mem[0] == 8'(d), {tag, " R2 addr0 dest"}, int'(mem[0]), d);
    chk_cnts(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int d, l, k, r;
    void'($urandom(32'd4242));
    repeat (3) tick();
    check(done == 1'b0 && wr_en == 1'b0, "R12 reset outputs", int'({done, wr_en}), 0);
    check(status == 2'd0, "R12 reset status", int'(status), 0);
    rst_n = 1'b1;
    tick();
    chk_cnts("R12 reset");

    // directed corners
    cap = 8'd2;  run_frame(8'h5A, 0, -1, "R1 cap2");
    cap = 8'd0;  run_frame(8'h5A, 1, 0, "R1 cap0 err");
    cap = 8'd3;  run_frame(8'h5A, 0, -1, "R4 exact fit 3");
    cap = 8'd3;  run_frame(8'h5A, 1, -1, "R5 one over");
    cap = 8'd20; run_frame(8'hFF, 17, -1, "R2 bcast exact");
    cap = 8'd20; run_frame(8'hFF, 18, -1, "R5 bcast over");
    cap = 8'd20; run_frame(8'h33, 4, -1, "R3 other addr");
    cap = 8'd20; run_frame(8'h33, 6, 3, "R8 other then err");
    cap = 8'd20; run_frame(8'h5A, 4, 0, "R6 err first");
    cap = 8'd20; run_frame(8'h5A, 4, 1, "R6 err len");
    cap = 8'd20; run_frame(8'h5A, 4, 6, "R6 err last");
    cap = 8'd255; run_frame(8'h5A, 255, -1, "R5 len 255");

    // R7: idle mid-frame, then a frame must follow without extra idle
    cap = 8'd30;
    wr_cnt = 0; done_cnt = 0;
    vld = 1'b1; dat = 8'h5A; tick();
    dat = 8'd5; tick();
    dat = 8'h11; tick();
    vld = 1'b0; idle = 1'b1; tick(); idle = 1'b0; tick();
    exp_io++;
    check(status == 2'd3, "R7 idle mid status", int'(status), 3);
    check(done_cnt == 1, "R7 idle mid done", done_cnt, 1);
    run_frame(8'h5A, 2, -1, "R7 next frame");

    // random mix
    for (int f = 0; f < 300; f++) begin
      cap = 8'($urandom_range(0, 32));
      node = 8'($urandom_range(0, 254));
      r = int'($urandom_range(0, 9));
      d = (r < 5) ? int'(node) : (r < 7) ? 255 : int'($urandom_range(0, 254));
      l = int'($urandom_range(0, 24));
      k = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, l + 2)) : -1;
      run_frame(d, l, k, "rand");
    end

    // R10: saturation on a 3-bit counter instance
    for (int i = 0; i < 10; i++) begin
      v1 = 1'b1; tick(); v1 = 1'b0;
      i1 = 1'b1; tick(); i1 = 1'b0;
    end
    tick();
    #1;
    check(cnt1 == 3'd7, "R10 saturate", int'(cnt1), 7);
    check(st1 == 2'd2, "R1 narrow size", int'(st1), 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule